// File: doc/BRIEF.md
# Averaged Overvoltage Flag Qualifier

This block watches a stream of digitized output-voltage samples and decides when an overvoltage condition is real enough to report. A free-running timer divides time into fixed averaging windows. Every strobed sample inside a window is added to an accumulator, and the window average is formed by a right shift. Each average is compared against a programmable limit.

A window whose average lies above the limit extends a run of consecutive bad windows. A window at or below the limit ends the run. A 2-bit count-select input says how long the run must be before the block acts. When the run is long enough, the block emits a one-cycle set pulse and raises a sticky flag. The flag stays high until an explicit clear. Sample conversion, register access and any shutdown response are outside the block.

Top module: `ov_avg_qualifier`

## Requirements
- R1: A window lasts WINDOW_CYCLES clock cycles. The first window starts at the first clock edge after reset is released, and the windows follow back to back. A strobed sample counts toward the window in which it is strobed, including a sample in the window's final cycle.
- R2: The window average is the sum of that window's strobed samples shifted right by AVG_SHIFT. If the shifted sum exceeds the largest DATA_W-bit value, the average saturates to that value and does not wrap.
- R3: A window is over-limit only when its average is strictly greater than `ov_limit`. An average equal to the limit is not over-limit. `ov_limit` must be held from a window's last cycle through the next clock edge.
- R4: The count code on `run_sel` sets how many consecutive over-limit windows are required: 0 needs 1, 1 needs 2, 2 needs 3 and 3 needs 4. The code is used at the second clock edge after a window's last cycle. The run count saturates at 4, so a run that continues keeps qualifying.
- R5: Any window at or below the limit resets the consecutive-window count to zero.
- R6: The set pulse is high for exactly one cycle, two clock edges after the last cycle of the window that completes a qualifying run. It goes high in every window that ends with a run at or above the required length.
- R7: `ov_flag` rises together with the set pulse and stays high until `clear`. If `clear` and a set happen in the same cycle, the flag stays set.
- R8: A synchronous reset clears the accumulator, the window timer, the run count, the set pulse and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | Sample valid strobe |
| smp_data | input | DATA_W | Unsigned voltage sample |
| ov_limit | input | DATA_W | Overvoltage limit compared with each window average |
| run_sel | input | CODE_W | Count code: the number of consecutive windows required is the code plus one |
| clear | input | 1 | Clears the sticky flag |
| ov_flag | output | 1 | Sticky overvoltage flag |
| set_pulse | output | 1 | One-cycle pulse when a run qualifies |

## Verification
The bench puts window averages exactly on the limit and one count above it. A comparison that used greater-or-equal would therefore flag one window too early. Windows densely filled with full-scale samples push the shifted sum beyond the output width. A wrapping average would then report a small value and miss the overvoltage.

Runs are broken by a single in-limit window, and the count code is changed partway through a run. A counter that does not clear or does not saturate would pulse in the wrong window or stop pulsing. Clears are placed just before, exactly on and after a set edge, so a design in which clear wins would drop the flag. A reset in the middle of a run checks that no stale count survives.

// File: rtl/ovq_pkg.sv
package ovq_pkg;

   // Result of one window comparison, valid for a single cycle
   typedef struct packed {
      logic valid;
      logic over;
   } ovq_res_t;

   // Number of consecutive windows needed for a given count code
   function automatic int unsigned ovq_need(input int unsigned code);
      return code + 1;
   endfunction

endpackage

// File: rtl/ovq_window_accum.sv
module ovq_window_accum #(
   parameter int DATA_W        = 12,
   parameter int WINDOW_CYCLES = 20000,
   parameter int AVG_SHIFT     = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              smp_stb,
   input  logic [DATA_W-1:0] smp_data,
   output logic              win_done,
   output logic [DATA_W-1:0] win_avg
);

   localparam int TMR_W  = $clog2(WINDOW_CYCLES);
   localparam int ACC_W  = DATA_W + $clog2(WINDOW_CYCLES + 1);
   localparam int HEAD_W = ACC_W - DATA_W;

   logic [TMR_W-1:0]  tmr_q;
   logic [ACC_W-1:0]  acc_q;
   logic [ACC_W-1:0]  acc_sum;
   logic [ACC_W-1:0]  acc_shr;
   logic [DATA_W-1:0] avg_sat;
   logic              last_cyc;

   assign last_cyc = (tmr_q == TMR_W'(WINDOW_CYCLES - 1));
   assign acc_sum  = acc_q + (smp_stb ? {{HEAD_W{1'b0}}, smp_data} : '0);
   assign acc_shr  = acc_sum >> AVG_SHIFT;

   // Clamp the shifted sum into the output width
   always_comb begin
      if (|acc_shr[ACC_W-1:DATA_W]) begin
         avg_sat = '1;
      end else begin
         avg_sat = acc_shr[DATA_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tmr_q    <= '0;
         acc_q    <= '0;
         win_done <= 1'b0;
         win_avg  <= '0;
      end else begin
         tmr_q    <= last_cyc ? '0 : tmr_q + 1'b1;
         acc_q    <= last_cyc ? '0 : acc_sum;
         win_done <= last_cyc;
         if (last_cyc) begin
            win_avg <= avg_sat;
         end
      end
   end

endmodule

// File: rtl/ovq_threshold_cmp.sv
module ovq_threshold_cmp
   import ovq_pkg::*;
#(
   parameter int DATA_W    = 12,
   parameter bit REG_STAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              win_done,
   input  logic [DATA_W-1:0] win_avg,
   input  logic [DATA_W-1:0] limit,
   output ovq_res_t          res
);

   ovq_res_t res_d;

   always_comb begin
      res_d.valid = win_done;
      res_d.over  = win_done && (win_avg > limit);
   end

   generate
      if (REG_STAGE) begin : g_reg
         ovq_res_t res_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               res_q <= '0;
            end else begin
               res_q <= res_d;
            end
         end
         assign res = res_q;
      end else begin : g_comb
         assign res = res_d;
      end
   endgenerate

endmodule

// File: rtl/ovq_run_qualifier.sv
module ovq_run_qualifier
   import ovq_pkg::*;
#(
   parameter int CODE_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  ovq_res_t          res,
   input  logic [CODE_W-1:0] run_sel,
   output logic              fire,
   output logic [CODE_W:0]   run_level
);

   localparam int RUN_W   = CODE_W + 1;
   localparam int MAX_RUN = 2 ** CODE_W;

   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] run_inc;
   logic [RUN_W-1:0] need;

   assign run_inc = (run_q == RUN_W'(MAX_RUN)) ? run_q : run_q + 1'b1;
   assign need    = RUN_W'(ovq_need(int'(run_sel)));

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= '0;
      end else if (res.valid) begin
         run_q <= res.over ? run_inc : '0;
      end
   end

   assign fire      = res.valid && res.over && (run_inc >= need);
   assign run_level = run_q;

endmodule

// File: rtl/ovq_sticky_flag.sv
module ovq_sticky_flag (
   input  logic clk,
   input  logic rst,
   input  logic fire,
   input  logic clear,
   output logic ov_flag,
   output logic set_pulse
);

   always_ff @(posedge clk) begin
      if (rst) begin
         ov_flag   <= 1'b0;
         set_pulse <= 1'b0;
      end else begin
         set_pulse <= fire;
         ov_flag   <= fire | (ov_flag & ~clear);
      end
   end

endmodule

// File: rtl/ov_avg_qualifier.sv
module ov_avg_qualifier
   import ovq_pkg::*;
#(
   parameter int DATA_W        = 12,
   parameter int WINDOW_CYCLES = 20000,
   parameter int AVG_SHIFT     = 4,
   parameter int CODE_W        = 2,
   parameter bit REG_STAGE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              smp_stb,
   input  logic [DATA_W-1:0] smp_data,
   input  logic [DATA_W-1:0] ov_limit,
   input  logic [CODE_W-1:0] run_sel,
   input  logic              clear,
   output logic              ov_flag,
   output logic              set_pulse
);

   localparam int RUN_W   = CODE_W + 1;
   localparam int MAX_RUN = 2 ** CODE_W;

   // Elaboration-time parameter checks
   generate
      if (WINDOW_CYCLES < 2) begin : g_bad_window
         $error("WINDOW_CYCLES must be at least 2");
      end
      if ((2 ** AVG_SHIFT) > WINDOW_CYCLES) begin : g_bad_shift
         $error("2**AVG_SHIFT must not exceed WINDOW_CYCLES");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code
         $error("CODE_W must lie in 1..4");
      end
   endgenerate

   logic              win_done;
   logic [DATA_W-1:0] win_avg;
   ovq_res_t          cmp_res;
   logic              fire;
   logic [RUN_W-1:0]  run_level;

   ovq_window_accum #(
      .DATA_W        (DATA_W),
      .WINDOW_CYCLES (WINDOW_CYCLES),
      .AVG_SHIFT     (AVG_SHIFT)
   ) u_accum (
      .clk      (clk),
      .rst      (rst),
      .smp_stb  (smp_stb),
      .smp_data (smp_data),
      .win_done (win_done),
      .win_avg  (win_avg)
   );

   ovq_threshold_cmp #(
      .DATA_W    (DATA_W),
      .REG_STAGE (REG_STAGE)
   ) u_cmp (
      .clk      (clk),
      .rst      (rst),
      .win_done (win_done),
      .win_avg  (win_avg),
      .limit    (ov_limit),
      .res      (cmp_res)
   );

   ovq_run_qualifier #(
      .CODE_W (CODE_W)
   ) u_run (
      .clk       (clk),
      .rst       (rst),
      .res       (cmp_res),
      .run_sel   (run_sel),
      .fire      (fire),
      .run_level (run_level)
   );

   ovq_sticky_flag u_flag (
      .clk       (clk),
      .rst       (rst),
      .fire      (fire),
      .clear     (clear),
      .ov_flag   (ov_flag),
      .set_pulse (set_pulse)
   );

endmodule

// File: rtl/ovq_checker.sv
module ovq_checker #(
   parameter int RUN_W   = 3,
   parameter int MAX_RUN = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             clear,
   input logic             ov_flag,
   input logic             set_pulse,
   input logic             res_valid,
   input logic             res_over,
   input logic [RUN_W-1:0] run_cnt
);

   // R7
   flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (ov_flag && !clear) |=> ov_flag);

   // R7
   clear_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      clear |=> (ov_flag == set_pulse));

   // R6
   pulse_from_window_chk: assert property (@(posedge clk) disable iff (rst)
      set_pulse |-> $past(res_valid && res_over));

   // R6
   pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
      set_pulse |=> !set_pulse);

   // R6
   pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
      set_pulse |-> ov_flag);

   // R5
   run_break_chk: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !res_over) |=> (run_cnt == '0));

   // R4
   run_cap_chk: assert property (@(posedge clk) disable iff (rst)
      run_cnt <= RUN_W'(MAX_RUN));

   // R8
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!ov_flag && !set_pulse && run_cnt == '0));

endmodule

bind ov_avg_qualifier ovq_checker #(
   .RUN_W   (RUN_W),
   .MAX_RUN (MAX_RUN)
) u_ovq_checker (
   .clk       (clk),
   .rst       (rst),
   .clear     (clear),
   .ov_flag   (ov_flag),
   .set_pulse (set_pulse),
   .res_valid (cmp_res.valid),
   .res_over  (cmp_res.over),
   .run_cnt   (run_level)
);

// File: tb/test_ov_avg_qualifier.sv
module test_ov_avg_qualifier;

   localparam int W    = 32;
   localparam int L    = 3;
   localparam int D    = 12;
   localparam int STEP = W / (2 ** L);
   localparam int DMAX = (2 ** D) - 1;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         smp_stb = 1'b0;
   logic [D-1:0] smp_data = '0;
   logic [D-1:0] ov_limit = '0;
   logic [1:0]   run_sel = '0;
   logic         clear = 1'b0;
   logic         ov_flag;
   logic         set_pulse;

   int n_checks = 0;
   int n_err    = 0;
   int ncyc     = 0;
   int win_id   = 0;
   bit finished = 1'b0;

   // scoreboard queues, one entry per window
   bit    q_pulse[$];
   bit    q_flag[$];
   string q_tag[$];
   int    q_win[$];

   // reference model state
   int m_run        = 0;
   bit m_flag       = 1'b0;
   bit m_last_pulse = 1'b0;

   always #2 clk = ~clk;

   ov_avg_qualifier #(
      .DATA_W        (D),
      .WINDOW_CYCLES (W),
      .AVG_SHIFT     (L),
      .CODE_W        (2),
      .REG_STAGE     (1'b1)
   ) i_ov_avg_qualifier (
      .clk       (clk),
      .rst       (rst),
      .smp_stb   (smp_stb),
      .smp_data  (smp_data),
      .ov_limit  (ov_limit),
      .run_sel   (run_sel),
      .clear     (clear),
      .ov_flag   (ov_flag),
      .set_pulse (set_pulse)
   );

   always @(posedge clk) begin
      if (rst) ncyc <= 0;
      else     ncyc <= ncyc + 1;
   end

   // Monitor: a window's result is visible after edge (k+1)*W+1 (R1, R6)
   always @(negedge clk) begin
      if (!rst) begin
         if (ncyc >= W + 2 && ((ncyc - 2) % W) == 0 && q_pulse.size() > 0) begin
            bit    ep;
            bit    ef;
            string tg;
            int    wn;
            ep = q_pulse.pop_front();
            ef = q_flag.pop_front();
            tg = q_tag.pop_front();
            wn = q_win.pop_front();
            n_checks++;
            if (set_pulse !== ep || ov_flag !== ef) begin
               n_err++;
               $display("FAIL %s/R6 window %0d: set_pulse=%0b expected %0b, ov_flag=%0b expected %0b",
                        tg, wn, set_pulse, ep, ov_flag, ef);
            end
         end else if (set_pulse !== 1'b0) begin
            n_checks++;
            n_err++;
            $display("FAIL R6 stray pulse at cycle %0d: set_pulse=%0b expected 0", ncyc, set_pulse);
         end
      end
   end

   // Driver: one window of stimulus plus the model prediction
   task automatic run_window(input string tag, input int val, input int bump, input int thr,
                             input int code, input int clr_at, input bit dense);
      int sum;
      int avg;
      bit over;
      bit pulse;
      int last_idx;
      sum = 0;
      last_idx = dense ? W - 1 : W - STEP;
      for (int i = 0; i < W; i++) begin
         bit stb;
         int v;
         stb = dense || ((i % STEP) == 0);
         v = (i == last_idx) ? bump : val;
         // limit and code change only after the previous window has been judged
         if (i == 2) begin
            ov_limit = thr[D-1:0];
            run_sel  = code[1:0];
         end
         smp_stb  = stb;
         smp_data = v[D-1:0];
         clear    = (i == clr_at);
         if (i == clr_at) begin
            if (clr_at <= 1) begin
               // clear lands on or before the previous window's set edge: set wins (R7)
               if (q_flag.size() > 0) q_flag[q_flag.size() - 1] = q_pulse[q_pulse.size() - 1];
               m_flag = m_last_pulse;
            end else begin
               m_flag = 1'b0;
            end
         end
         if (stb) sum += v;
         @(negedge clk);
      end
      smp_stb = 1'b0;
      clear   = 1'b0;
      avg = sum >> L;
      if (avg > DMAX) avg = DMAX;
      over = (avg > thr);
      if (over) m_run = (m_run < 4) ? m_run + 1 : 4;
      else      m_run = 0;
      pulse = over && (m_run >= code + 1);
      m_flag = m_flag | pulse;
      m_last_pulse = pulse;
      q_pulse.push_back(pulse);
      q_flag.push_back(m_flag);
      q_tag.push_back(tag);
      q_win.push_back(win_id);
      win_id++;
   endtask

   task automatic check_idle(input string tag);
      n_checks++;
      if (ov_flag !== 1'b0 || set_pulse !== 1'b0) begin
         n_err++;
         $display("FAIL %s reset: ov_flag=%0b set_pulse=%0b expected 0 0", tag, ov_flag, set_pulse);
      end
   endtask

   task automatic do_reset();
      repeat (3) @(negedge clk);
      rst = 1'b1;
      smp_stb = 1'b0;
      clear = 1'b0;
      repeat (2) @(negedge clk);
      check_idle("R8");
      m_run = 0;
      m_flag = 1'b0;
      m_last_pulse = 1'b0;
      rst = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_idle("R8");
      rst = 1'b0;

      // R3: below then above the limit, code 0 needs one window
      run_window("R3", 900, 900, 1000, 0, -1, 1'b0);
      run_window("R4", 1001, 1001, 1000, 0, -1, 1'b0);
      // R7: clear late in a quiet window drops the flag
      run_window("R7", 900, 900, 1000, 0, 5, 1'b0);
      // R3: average equal to the limit, then one above
      run_window("R3", 1000, 1007, 1000, 0, -1, 1'b0);
      run_window("R3", 1000, 1008, 1000, 0, -1, 1'b0);
      // R7: clear on the set edge, then clear with no set
      run_window("R7", 900, 900, 1000, 0, 1, 1'b0);
      run_window("R7", 900, 900, 1000, 0, 1, 1'b0);
      run_window("R7", 1001, 1001, 1000, 0, -1, 1'b0);
      run_window("R7", 900, 900, 1000, 0, 0, 1'b0);
      // R5: code 1, run broken then completed
      run_window("R5", 1001, 1001, 1000, 1, 3, 1'b0);
      run_window("R5", 900, 900, 1000, 1, -1, 1'b0);
      run_window("R5", 1001, 1001, 1000, 1, -1, 1'b0);
      run_window("R4", 1001, 1001, 1000, 1, -1, 1'b0);
      // R4: code 3 needs four, saturating run keeps firing
      run_window("R4", 900, 900, 1000, 3, -1, 1'b0);
      for (int k = 0; k < 5; k++) run_window("R4", 1100, 1100, 1000, 3, -1, 1'b0);
      // R5: code 2 with a break after two
      run_window("R5", 900, 900, 1000, 2, 4, 1'b0);
      run_window("R5", 1200, 1200, 1000, 2, -1, 1'b0);
      run_window("R5", 1200, 1200, 1000, 2, -1, 1'b0);
      run_window("R5", 900, 900, 1000, 2, -1, 1'b0);
      for (int k = 0; k < 3; k++) run_window("R5", 1200, 1200, 1000, 2, -1, 1'b0);
      // R4: code changed mid-run is used at the window's end
      run_window("R4", 900, 900, 1000, 3, 6, 1'b0);
      run_window("R4", 1100, 1100, 1000, 3, -1, 1'b0);
      run_window("R4", 1100, 1100, 1000, 3, -1, 1'b0);
      run_window("R4", 1100, 1100, 1000, 0, -1, 1'b0);
      // R1: dense strobes, the final-cycle sample decides
      run_window("R1", 250, 250, 1000, 0, 3, 1'b1);
      run_window("R1", 250, 258, 1000, 0, -1, 1'b1);
      // R2: average is a shift, and it saturates rather than wraps
      run_window("R2", 512, 512, 2047, 0, 3, 1'b1);
      run_window("R2", 512, 512, 2048, 0, -1, 1'b1);
      run_window("R2", DMAX, DMAX, DMAX - 1, 0, -1, 1'b1);
      // R8: reset mid-run leaves no stale count
      run_window("R8", 900, 900, 1000, 3, -1, 1'b0);
      for (int k = 0; k < 3; k++) run_window("R8", 1100, 1100, 1000, 3, -1, 1'b0);
      do_reset();
      for (int k = 0; k < 4; k++) run_window("R8", 1100, 1100, 1000, 3, -1, 1'b0);
      repeat (4) @(negedge clk);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
         $finish;
      end
   end

endmodule